// File: doc/BRIEF.md
# Tiered Vectored Interrupt Controller

This controller gathers interrupt requests for a small CPU core and decides, at each instruction boundary, which request the core takes next. Peripheral requests come in as level flag bits, each qualified by an enable bit. A source that has no enable register is treated as always enabled. Three further sources arrive as one-cycle raise strobes: a software trap, an illegal-opcode trap and a non-maskable external request. Every qualified request sets a bit in a pending vector, and that bit stays set until the request is accepted.

Arbitration runs in tiers. The two trap sources come first and ignore both CPU mask bits. The external request comes next and is gated only by the X mask. Below it, the remaining sources are gated by the I mask and ranked by a writable priority table. On acceptance the block reports the id and the vector address, and it strobes which nesting mask the core must set. It also tells the core how many stall cycles the entry sequence costs. Stacking, the vector memory read and the peripherals themselves live outside this block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Peripheral i (ids 0..N_PERIPH-1, default 8) sets pending bit i in any cycle where its flag is 1 and either its enable is 1 or bit i of NO_EN_MASK is 1. The default NO_EN_MASK is 8'hC0, so ids 6 and 7 need no enable.
- R2: At a boundary, a pending software trap (id 15) wins over everything, then a pending illegal-opcode trap (id 14). Both are taken whatever the values of mask_i and mask_x.
- R3: A pending external request (id 13) is taken only when mask_x is 0. It beats every I-maskable source, and it is considered regardless of mask_i.
- R4: While mask_i is 1, no I-maskable source is taken. Their pending bits are kept and are served once mask_i returns to 0.
- R5: Among I-maskable sources (ids other than 13, 14 and 15), the winner is the source named by the lowest table entry k whose named source is pending. After reset, entry k holds k.
- R6: Acceptance clears only the winner's pending bit. If the same source raises again in the accepting cycle, its bit stays set.
- R7: With a valid acceptance, vec_addr = 16'hFFC0 + 2*irq_id. Without one, vec_addr is 0.
- R8: An acceptance of id 13 pulses set_x. Any other acceptance pulses set_i. Exactly one of the two pulses with each acceptance, and neither pulses otherwise.
- R9: stall_cyc is 14 in an accepting cycle and 0 otherwise.
- R10: A write with tbl_we=1 stores tbl_val into entry tbl_idx, and it takes effect from the next cycle. Duplicate ids are allowed, and the first entry in walk order wins.
- R11: A boundary with no eligible pending source leaves irq_valid, set_i and set_x low.
- R12: The outputs are registered and appear in the cycle after the boundary strobe. In a cycle with no boundary strobe, irq_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_flag | input | N_PERIPH | Peripheral request flags |
| periph_en | input | N_PERIPH | Peripheral enable bits |
| raise_swi | input | 1 | Software-trap raise strobe |
| raise_ill | input | 1 | Illegal-opcode raise strobe |
| raise_xreq | input | 1 | Non-maskable external request strobe |
| mask_i | input | 1 | CPU I mask bit |
| mask_x | input | 1 | CPU X mask bit |
| insn_bnd | input | 1 | Instruction boundary strobe |
| tbl_we | input | 1 | Priority table write enable |
| tbl_idx | input | ID_W | Table entry to write |
| tbl_val | input | ID_W | Source id to store |
| irq_valid | output | 1 | An interrupt was accepted |
| irq_id | output | ID_W | Accepted id |
| vec_addr | output | ADDR_W | Vector fetch address |
| set_i | output | 1 | Core must set I mask |
| set_x | output | 1 | Core must set X mask |
| stall_cyc | output | STALL_W | Stall cycles to add |

## Verification
On every cycle, the assertions check how the outputs relate to one another and to the inputs of the cycle before. These checks cover the valid-only-after-boundary rule, the mask strobe that matches the accepted class, the mask gating of the external and I-maskable classes, the vector address and the stall count. The assertions cannot see which pending source should have won, or whether the other pending bits survived an acceptance. Those properties only show up in the bench scenarios. The bench sweeps every flag pattern against varied enables, stacks traps behind both masks, reorders the table and writes duplicate entries, and drains each scenario against an arithmetic model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    CLS_NONE     = 2'd0,
    CLS_TRAP     = 2'd1,
    CLS_XREQ     = 2'd2,
    CLS_MASKABLE = 2'd3
  } irq_class_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int ID_W     = 4,
  parameter int N_PERIPH = 8,
  parameter logic [N_PERIPH-1:0] NO_EN_MASK = '0,
  parameter int SWI_ID   = 15,
  parameter int ILL_ID   = 14,
  parameter int XIRQ_ID  = 13,
  localparam int N_IDS   = 1 << ID_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PERIPH-1:0] periph_flag,
  input  logic [N_PERIPH-1:0] periph_en,
  input  logic                raise_swi,
  input  logic                raise_ill,
  input  logic                raise_xreq,
  input  logic                clr_en,
  input  logic [ID_W-1:0]     clr_id,
  output logic [N_IDS-1:0]    pend
);
  logic [N_IDS-1:0] set_vec;
  logic [N_IDS-1:0] clr_vec;

  // Per-id request sources; ids that are neither a peripheral nor a trap stay idle.
  for (genvar g = 0; g < N_IDS; g++) begin : g_src
    if (g == SWI_ID) begin : g_swi
      assign set_vec[g] = raise_swi;
    end else if (g == ILL_ID) begin : g_ill
      assign set_vec[g] = raise_ill;
    end else if (g == XIRQ_ID) begin : g_x
      assign set_vec[g] = raise_xreq;
    end else if (g < N_PERIPH) begin : g_per
      assign set_vec[g] = periph_flag[g] & (periph_en[g] | NO_EN_MASK[g]);
    end else begin : g_none
      assign set_vec[g] = 1'b0;
    end
    assign clr_vec[g] = clr_en && (clr_id == ID_W'(g));
  end

  // A fresh raise in the clearing cycle wins over the clear.
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/irq_prio_table.sv
module irq_prio_table #(
  parameter int ID_W = 4,
  localparam int N_IDS = 1 << ID_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ID_W-1:0]       widx,
  input  logic [ID_W-1:0]       wval,
  output logic [N_IDS*ID_W-1:0] tbl_flat
);
  // All entries are read in parallel by the arbiter, so storage is flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_IDS; k++) tbl_flat[k*ID_W +: ID_W] <= ID_W'(k);
    end else if (we) begin
      tbl_flat[widx*ID_W +: ID_W] <= wval;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int ID_W    = 4,
  parameter int SWI_ID  = 15,
  parameter int ILL_ID  = 14,
  parameter int XIRQ_ID = 13,
  localparam int N_IDS  = 1 << ID_W
) (
  input  logic [N_IDS-1:0]      pend,
  input  logic [N_IDS*ID_W-1:0] tbl_flat,
  input  logic                  mask_i,
  input  logic                  mask_x,
  output logic                  hit,
  output logic [ID_W-1:0]       win_id,
  output irq_class_e            win_cls
);
  localparam logic [ID_W-1:0] SWI_L  = ID_W'(SWI_ID);
  localparam logic [ID_W-1:0] ILL_L  = ID_W'(ILL_ID);
  localparam logic [ID_W-1:0] XIRQ_L = ID_W'(XIRQ_ID);

  logic            m_hit;
  logic [ID_W-1:0] m_id;
  logic [ID_W-1:0] ent;

  // Walk the table from the bottom up so the lowest matching entry is kept.
  always_comb begin
    m_hit = 1'b0;
    m_id  = '0;
    ent   = '0;
    for (int k = N_IDS - 1; k >= 0; k--) begin
      ent = tbl_flat[k*ID_W +: ID_W];
      if (pend[ent] && ent != SWI_L && ent != ILL_L && ent != XIRQ_L) begin
        m_hit = 1'b1;
        m_id  = ent;
      end
    end
  end

  always_comb begin
    hit     = 1'b1;
    win_id  = '0;
    win_cls = CLS_NONE;
    if (pend[SWI_L]) begin
      win_id = SWI_L; win_cls = CLS_TRAP;
    end else if (pend[ILL_L]) begin
      win_id = ILL_L; win_cls = CLS_TRAP;
    end else if (pend[XIRQ_L] && !mask_x) begin
      win_id = XIRQ_L; win_cls = CLS_XREQ;
    end else if (!mask_i && m_hit) begin
      win_id = m_id; win_cls = CLS_MASKABLE;
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int N_PERIPH  = 8,
  parameter logic [N_PERIPH-1:0] NO_EN_MASK = 8'hC0,
  parameter int SWI_ID    = 15,
  parameter int ILL_ID    = 14,
  parameter int XIRQ_ID   = 13,
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0,
  parameter int STALL_CYC = 14,
  parameter int STALL_W   = 5,
  localparam int N_IDS    = 1 << ID_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PERIPH-1:0] periph_flag,
  input  logic [N_PERIPH-1:0] periph_en,
  input  logic                raise_swi,
  input  logic                raise_ill,
  input  logic                raise_xreq,
  input  logic                mask_i,
  input  logic                mask_x,
  input  logic                insn_bnd,
  input  logic                tbl_we,
  input  logic [ID_W-1:0]     tbl_idx,
  input  logic [ID_W-1:0]     tbl_val,
  output logic                irq_valid,
  output logic [ID_W-1:0]     irq_id,
  output logic [ADDR_W-1:0]   vec_addr,
  output logic                set_i,
  output logic                set_x,
  output logic [STALL_W-1:0]  stall_cyc
);
  logic [N_IDS-1:0]      pend;
  logic [N_IDS*ID_W-1:0] tbl_flat;
  logic                  hit;
  logic [ID_W-1:0]       win_id;
  irq_class_e            win_cls;
  logic                  take;

  assign take = insn_bnd && hit;

  irq_pend #(
    .ID_W(ID_W), .N_PERIPH(N_PERIPH), .NO_EN_MASK(NO_EN_MASK),
    .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .XIRQ_ID(XIRQ_ID)
  ) u_pend (
    .clk(clk), .rst(rst), .periph_flag(periph_flag), .periph_en(periph_en),
    .raise_swi(raise_swi), .raise_ill(raise_ill), .raise_xreq(raise_xreq),
    .clr_en(take), .clr_id(win_id), .pend(pend)
  );

  irq_prio_table #(.ID_W(ID_W)) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .widx(tbl_idx), .wval(tbl_val),
    .tbl_flat(tbl_flat)
  );

  irq_arbiter #(
    .ID_W(ID_W), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .XIRQ_ID(XIRQ_ID)
  ) u_arb (
    .pend(pend), .tbl_flat(tbl_flat), .mask_i(mask_i), .mask_x(mask_x),
    .hit(hit), .win_id(win_id), .win_cls(win_cls)
  );

  always_ff @(posedge clk) begin
    if (rst || !take) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
      vec_addr  <= '0;
      set_i     <= 1'b0;
      set_x     <= 1'b0;
      stall_cyc <= '0;
    end else begin
      irq_valid <= 1'b1;
      irq_id    <= win_id;
      vec_addr  <= VEC_BASE + ADDR_W'({win_id, 1'b0});
      set_x     <= (win_cls == CLS_XREQ);
      set_i     <= (win_cls != CLS_XREQ);
      stall_cyc <= STALL_W'(STALL_CYC);
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int ID_W      = 4,
  parameter int SWI_ID    = 15,
  parameter int ILL_ID    = 14,
  parameter int XIRQ_ID   = 13,
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0,
  parameter int STALL_CYC = 14,
  parameter int STALL_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               mask_i,
  input logic               mask_x,
  input logic               insn_bnd,
  input logic               irq_valid,
  input logic [ID_W-1:0]    irq_id,
  input logic [ADDR_W-1:0]  vec_addr,
  input logic               set_i,
  input logic               set_x,
  input logic [STALL_W-1:0] stall_cyc
);
  logic is_x, is_trap;
  assign is_x    = (irq_id == ID_W'(XIRQ_ID));
  assign is_trap = (irq_id == ID_W'(SWI_ID)) || (irq_id == ID_W'(ILL_ID));

  a_r12_after_bnd: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $past(insn_bnd));
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (set_i ^ set_x));
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> (!set_i && !set_x));
  a_r8_x_class: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && is_x) |-> set_x);
  a_r3_x_gate: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && is_x) |-> !$past(mask_x));
  a_r4_i_gate: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !is_x && !is_trap) |-> !$past(mask_i));
  a_r7_vector: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (vec_addr == VEC_BASE + ADDR_W'({irq_id, 1'b0})));
  a_r9_stall_on: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (stall_cyc == STALL_W'(STALL_CYC)));
  a_r9_stall_off: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> (stall_cyc == '0));
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(
  .ID_W(ID_W), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .XIRQ_ID(XIRQ_ID),
  .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .STALL_CYC(STALL_CYC), .STALL_W(STALL_W)
) u_chk (
  .clk(clk), .rst(rst), .mask_i(mask_i), .mask_x(mask_x), .insn_bnd(insn_bnd),
  .irq_valid(irq_valid), .irq_id(irq_id), .vec_addr(vec_addr),
  .set_i(set_i), .set_x(set_x), .stall_cyc(stall_cyc)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] periph_flag = '0, periph_en = '0;
  logic       raise_swi = 0, raise_ill = 0, raise_xreq = 0;
  logic       mask_i = 0, mask_x = 0, insn_bnd = 0;
  logic       tbl_we = 0;
  logic [3:0] tbl_idx = '0, tbl_val = '0;
  logic        irq_valid, set_i, set_x;
  logic [3:0]  irq_id;
  logic [15:0] vec_addr;
  logic [4:0]  stall_cyc;

  int checks = 0, errors = 0;
  logic [15:0] mpend = '0;
  logic [3:0]  mtbl [16];
  string       scen = "";

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .periph_flag(periph_flag), .periph_en(periph_en),
    .raise_swi(raise_swi), .raise_ill(raise_ill), .raise_xreq(raise_xreq),
    .mask_i(mask_i), .mask_x(mask_x), .insn_bnd(insn_bnd),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_val(tbl_val),
    .irq_valid(irq_valid), .irq_id(irq_id), .vec_addr(vec_addr),
    .set_i(set_i), .set_x(set_x), .stall_cyc(stall_cyc)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Tiered choice from the requirements: traps, then external, then table walk.
  task automatic pick(input logic [15:0] p, input bit mi, input bit mx,
                      output bit v, output logic [3:0] id, output string tag);
    v = 1; id = '0; tag = "";
    if (p[15]) begin id = 15; tag = "R2"; end
    else if (p[14]) begin id = 14; tag = "R2"; end
    else if (p[13] && !mx) begin id = 13; tag = "R3"; end
    else begin
      v = 0;
      if (!mi) begin
        for (int k = 0; k < 16; k++) begin
          if (!v && p[mtbl[k]] && mtbl[k] < 13) begin
            v = 1; id = mtbl[k];
          end
        end
      end
      if (v) tag = (scen != "") ? scen : "R5";
      else   tag = (mi && (p[12:0] != 0)) ? "R4" : "R11";
    end
  endtask

  task automatic step(input logic [7:0] f, input logic [7:0] e, input bit sw,
                      input bit il, input bit xr, input bit bnd,
                      input bit mi, input bit mx);
    bit ev; logic [3:0] eid; string tag; logic [15:0] setv, clrv;
    @(negedge clk);
    periph_flag = f; periph_en = e; raise_swi = sw; raise_ill = il;
    raise_xreq = xr; insn_bnd = bnd; mask_i = mi; mask_x = mx;
    pick(mpend, mi, mx, ev, eid, tag);
    if (!bnd) begin ev = 0; tag = "R12"; end
    setv = '0;
    for (int i = 0; i < 8; i++)
      setv[i] = f[i] & (e[i] | (i >= 6));
    setv[15] = sw; setv[14] = il; setv[13] = xr;
    clrv = ev ? (16'h1 << eid) : 16'h0;
    mpend = (mpend & ~clrv) | setv;
    if (tbl_we) mtbl[tbl_idx] = tbl_val;
    @(posedge clk); #1;
    tbl_we = 0;
    chk(irq_valid == ev && (!ev || irq_id == eid), tag,
        {irq_valid, irq_id}, {ev, eid});
    chk(vec_addr == (ev ? 16'hFFC0 + {11'd0, eid, 1'b0} : 16'h0), "R7",
        vec_addr, ev ? 16'hFFC0 + {11'd0, eid, 1'b0} : 16'h0);
    chk(set_x == (ev && eid == 13) && set_i == (ev && eid != 13), "R8",
        {set_i, set_x}, {ev && eid != 13, ev && eid == 13});
    chk(stall_cyc == (ev ? 5'd14 : 5'd0), "R9", stall_cyc, ev ? 14 : 0);
  endtask

  task automatic drain(input bit mi, input bit mx);
    for (int n = 0; n < 18; n++) step(8'h00, 8'h00, 0, 0, 0, 1, mi, mx);
  endtask

  task automatic wr(input logic [3:0] idx, input logic [3:0] val);
    @(negedge clk);
    tbl_we = 1; tbl_idx = idx; tbl_val = val;
    step(8'h00, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) mtbl[k] = 4'(k);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk(!irq_valid && vec_addr == 0 && !set_i && !set_x && stall_cyc == 0,
        "R12", {irq_valid, vec_addr}, 0);

    // R1 and R5: every flag pattern against a varied enable, then drained.
    for (int f = 0; f < 256; f++) begin
      step(8'(f), 8'(f * 37 + 11), 0, 0, 0, 0, 0, 0);
      drain(0, 0);
    end

    // R2, R3, R4: traps and the external request behind both masks.
    for (int f = 1; f < 256; f += 17) begin
      step(8'(f), 8'hFF, 1, 1, 1, 0, 1, 1);
      step(8'h00, 8'h00, 0, 0, 0, 1, 1, 1);
      step(8'h00, 8'h00, 0, 0, 0, 1, 1, 1);
      step(8'h00, 8'h00, 0, 0, 0, 1, 1, 1);
      step(8'h00, 8'h00, 0, 0, 0, 1, 1, 0);
      step(8'h00, 8'h00, 0, 0, 0, 1, 1, 1);
      drain(0, 1);
    end

    // R3: external request wins over maskable sources when X is clear.
    step(8'h01, 8'h01, 0, 0, 1, 0, 0, 0);
    drain(0, 0);

    // R6: a source re-raised in its accepting cycle stays pending.
    scen = "R6";
    step(8'h24, 8'hFF, 0, 0, 0, 0, 0, 0);
    step(8'h04, 8'hFF, 0, 0, 0, 1, 0, 0);
    drain(0, 0);

    // R10: reversed table, then duplicate entries.
    scen = "R10";
    for (int k = 0; k < 16; k++) wr(4'(k), 4'(15 - k));
    step(8'h81, 8'hFF, 0, 0, 0, 0, 0, 0);
    drain(0, 0);
    wr(4'd0, 4'd3);
    wr(4'd1, 4'd3);
    wr(4'd2, 4'd5);
    step(8'h28, 8'hFF, 0, 0, 0, 0, 0, 0);
    drain(0, 0);
    for (int f = 0; f < 256; f += 7) begin
      step(8'(f), 8'hFF, 0, 0, 0, 0, 0, 0);
      drain(0, 0);
    end
    scen = "";

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule